// File: doc/BRIEF.md
# Modem Status Change Detector

This block watches two slow modem input lines, clear-to-send and carrier-detect, and tells a host status path when either one has settled at a new level. The lines are sampled only on a periodic tick that is counted out of the system clock. Detection therefore carries on when the transmit and receive serial clocks are stopped. A new level is accepted only after it has been seen on two tick samples in a row, so a one-sample glitch is filtered out.

Each accepted change raises a one-cycle pulse for that line and sets a sticky pending flag, which stays set until the host acknowledges it. Both are raised only while the detect enable is high. With the enable low, the filtered level still follows the line.

The block also answers a pin-read request with the filtered input levels and the present request-to-send level. It holds the request-to-send output, which resets high and changes only on a host write.

Top module: `modem_line_watch`

## Requirements
- R1: The sampling tick acts on every TICK_CYCLES-th rising edge of the system clock after reset is released. The first sample is taken on edge number TICK_CYCLES. No serial clock takes part.
- R2: The first tick sample after reset loads the filtered level of each line and produces no pulse and no pending flag. Until that tick, the filtered levels read as 0.
- R3: A filtered level changes only when two consecutive tick samples both differ from it. A single differing sample followed by a sample equal to the old level leaves the level unchanged.
- R4: When a change is accepted at a tick with detect_en high, chg_pulse goes high for exactly the next cycle, on bit 0 for clear-to-send and bit 1 for carrier-detect.
- R5: A change accepted while detect_en is low updates the filtered level but raises no pulse and sets no pending flag.
- R6: chg_pend for a line is set together with its pulse and holds until chg_ack for that bit is high at a clock edge. If the set and the acknowledge come at the same edge, the set wins.
- R7: rd_req high at an edge gives rd_valid high for the next cycle only. rd_data then holds the values from before that edge: bit 0 is the clear-to-send level, bit 1 the carrier-detect level, bit 2 the request-to-send output.
- R8: rts_out is high during and after reset. It takes rts_wr_val at an edge where rts_wr is high and holds its value at every other edge.
- R9: The two lines are filtered and reported independently of each other.
- R10: During reset, chg_pulse, chg_pend and rd_valid are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous reset, active low |
| detect_en | input | 1 | Enables change pulses and pending flags |
| cts_in | input | 1 | Clear-to-send line, asynchronous |
| cd_in | input | 1 | Carrier-detect line, asynchronous |
| rts_wr | input | 1 | Host write strobe for request-to-send |
| rts_wr_val | input | 1 | Level written to request-to-send |
| rts_out | output | 1 | Request-to-send output |
| rd_req | input | 1 | Pin-read request |
| rd_valid | output | 1 | Read data valid, one cycle |
| rd_data | output | 3 | {rts, cd level, cts level} |
| chg_ack | input | 2 | Per-line clear of the pending flag |
| chg_pulse | output | 2 | Per-line one-cycle change event |
| chg_pend | output | 2 | Per-line sticky change flag |

## Verification
The assertions check on every cycle that the tick is a single-cycle strobe and that a filtered level moves only on a tick edge. They also check that a pulse never lasts two cycles and never appears without the enable, that a pending flag rises only with its pulse, that request-to-send moves only on a write, and that every read request gets exactly one valid cycle. Some behaviours can be shown only by the bench's scenarios, because they depend on the order of samples and on values: the glitch that is rejected after one differing sample, the priming at the first tick, a level that is updated silently while detection is disabled, the set-over-acknowledge priority, and read data that shows the state from before the edge.

// File: rtl/mlw_pkg.sv
// Shared constants and types for the modem line watcher.
// Assumes exactly two watched lines; bit order is part of the read format.
package mlw_pkg;
    localparam int NUM_LINES = 2;
    localparam int LINE_CTS  = 0;
    localparam int LINE_CD   = 1;
    localparam int RD_W      = NUM_LINES + 1;   // levels plus request-to-send

    typedef enum logic [1:0] {
        FS_UNPRIMED = 2'd0,   // no sample taken since reset
        FS_STEADY   = 2'd1,   // last sample matched the filtered level
        FS_SUSPECT  = 2'd2    // one differing sample seen, awaiting confirmation
    } filt_state_e;
endpackage

// File: rtl/mlw_tick_gen.sv
// Periodic sampling strobe counted from the system clock.
// Assumes TICK_CYCLES >= 2; the strobe is high for one cycle out of TICK_CYCLES.
module mlw_tick_gen #(
    parameter int TICK_CYCLES = 400000
) (
    input  logic clk,
    input  logic rst_n,
    output logic tick_o
);
    localparam int CNT_W = (TICK_CYCLES > 2) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [CNT_W-1:0] LAST = CNT_W'(TICK_CYCLES - 1);

    logic [CNT_W-1:0] cnt_q;

    // strobe when the counter reaches its last value
    assign tick_o = (cnt_q == LAST);

    // free-running period counter
    always_ff @(posedge clk) begin
        if (!rst_n)      cnt_q <= '0;
        else if (tick_o) cnt_q <= '0;
        else             cnt_q <= cnt_q + 1'b1;
    end

    p_tick_single_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> !tick_o);
    p_tick_restart_r1: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/mlw_line_filter.sv
// Two-sample confirmation filter for one asynchronous modem line.
// Synchronises the line, samples it on tick_i, and reports accepted changes
// as a pulse and a sticky flag while en_i is high. Assumes ticks at least
// two cycles apart.
module mlw_line_filter
    import mlw_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic tick_i,
    input  logic en_i,
    input  logic raw_i,
    input  logic ack_i,
    output logic level_o,
    output logic pulse_o,
    output logic pend_o
);
    logic [1:0]  sync_q;
    filt_state_e state_q;
    logic        level_q;
    logic        pulse_q;
    logic        pend_q;
    logic        smp;
    logic        accept;

    assign smp    = sync_q[1];
    assign accept = tick_i && (state_q == FS_SUSPECT) && (smp != level_q);

    // two-flop synchroniser for the asynchronous line
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b00;
        else        sync_q <= {sync_q[0], raw_i};
    end

    // confirmation state machine and filtered level, advanced on ticks only
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= FS_UNPRIMED;
            level_q <= 1'b0;
        end else if (tick_i) begin
            unique case (state_q)
                FS_UNPRIMED: begin
                    level_q <= smp;
                    state_q <= FS_STEADY;
                end
                FS_STEADY: begin
                    if (smp != level_q) state_q <= FS_SUSPECT;
                end
                FS_SUSPECT: begin
                    if (smp != level_q) level_q <= smp;
                    state_q <= FS_STEADY;
                end
                default: state_q <= FS_STEADY;
            endcase
        end
    end

    // one-cycle change event when detection is enabled
    always_ff @(posedge clk) begin
        if (!rst_n) pulse_q <= 1'b0;
        else        pulse_q <= accept && en_i;
    end

    // sticky flag: set wins over acknowledge
    always_ff @(posedge clk) begin
        if (!rst_n)               pend_q <= 1'b0;
        else if (accept && en_i)  pend_q <= 1'b1;
        else if (ack_i)           pend_q <= 1'b0;
    end

    assign level_o = level_q;
    assign pulse_o = pulse_q;
    assign pend_o  = pend_q;

    p_level_on_tick_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (level_q != $past(level_q)) |-> $past(tick_i));
    p_pulse_needs_en_r5: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |-> $past(en_i && tick_i));
    p_pulse_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);
    p_pend_rise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q) |-> pulse_q);
    p_pend_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_q && !ack_i) |=> pend_q);
endmodule

// File: rtl/mlw_host_port.sv
// Host side: request-to-send register and registered pin-read response.
// Read data shows the state from before the requesting edge.
module mlw_host_port
    import mlw_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] levels_i,
    input  logic                 rts_wr_i,
    input  logic                 rts_val_i,
    input  logic                 rd_req_i,
    output logic                 rts_o,
    output logic                 rd_valid_o,
    output logic [RD_W-1:0]      rd_data_o
);
    logic            rts_q;
    logic            rd_valid_q;
    logic [RD_W-1:0] rd_data_q;

    // request-to-send level, high out of reset
    always_ff @(posedge clk) begin
        if (!rst_n)        rts_q <= 1'b1;
        else if (rts_wr_i) rts_q <= rts_val_i;
    end

    // capture the pin snapshot on a read request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid_q <= 1'b0;
            rd_data_q  <= '0;
        end else begin
            rd_valid_q <= rd_req_i;
            if (rd_req_i) rd_data_q <= {rts_q, levels_i};
        end
    end

    assign rts_o      = rts_q;
    assign rd_valid_o = rd_valid_q;
    assign rd_data_o  = rd_data_q;

    p_rts_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !rts_wr_i |=> $stable(rts_o));
    p_rd_answer_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rd_req_i |=> rd_valid_o);
    p_rd_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_req_i |=> !rd_valid_o);
endmodule

// File: rtl/modem_line_watch.sv
// Top level: tick generator, one confirmation filter per modem line, and
// the host port. Line order: bit 0 clear-to-send, bit 1 carrier-detect.
module modem_line_watch
    import mlw_pkg::*;
#(
    parameter int TICK_CYCLES = 400000
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 detect_en,
    input  logic                 cts_in,
    input  logic                 cd_in,
    input  logic                 rts_wr,
    input  logic                 rts_wr_val,
    output logic                 rts_out,
    input  logic                 rd_req,
    output logic                 rd_valid,
    output logic [RD_W-1:0]      rd_data,
    input  logic [NUM_LINES-1:0] chg_ack,
    output logic [NUM_LINES-1:0] chg_pulse,
    output logic [NUM_LINES-1:0] chg_pend
);
    logic                 tick;
    logic [NUM_LINES-1:0] raw;
    logic [NUM_LINES-1:0] levels;

    assign raw[LINE_CTS] = cts_in;
    assign raw[LINE_CD]  = cd_in;

    mlw_tick_gen #(.TICK_CYCLES(TICK_CYCLES)) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .tick_o (tick)
    );

    for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
        mlw_line_filter u_filt (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick_i  (tick),
            .en_i    (detect_en),
            .raw_i   (raw[g]),
            .ack_i   (chg_ack[g]),
            .level_o (levels[g]),
            .pulse_o (chg_pulse[g]),
            .pend_o  (chg_pend[g])
        );
    end

    mlw_host_port u_host (
        .clk        (clk),
        .rst_n      (rst_n),
        .levels_i   (levels),
        .rts_wr_i   (rts_wr),
        .rts_val_i  (rts_wr_val),
        .rd_req_i   (rd_req),
        .rts_o      (rts_out),
        .rd_valid_o (rd_valid),
        .rd_data_o  (rd_data)
    );
endmodule

// File: tb/modem_line_watch_tb.sv
// Bench: directed corner cases followed by seeded random stimulus, compared
// every cycle against a reference model kept in the bench.
module modem_line_watch_tb;
    localparam int T = 16;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       detect_en = 1'b1;
    logic [1:0] line_drv = 2'b11;
    logic       rts_wr = 1'b0;
    logic       rts_wr_val = 1'b0;
    logic       rts_out;
    logic       rd_req = 1'b0;
    logic       rd_valid;
    logic [2:0] rd_data;
    logic [1:0] chg_ack = 2'b00;
    logic [1:0] chg_pulse;
    logic [1:0] chg_pend;

    int n_cmp = 0;
    int n_bad = 0;
    int n = 0;
    bit done = 0;

    // model state
    bit [1:0] m_primed = '0, m_lvl = '0, m_cand = '0, m_pend = '0;
    bit       m_rts = 1'b1;

    always #10 clk = ~clk;

    modem_line_watch #(.TICK_CYCLES(T)) u_dut (
        .clk(clk), .rst_n(rst_n), .detect_en(detect_en),
        .cts_in(line_drv[0]), .cd_in(line_drv[1]),
        .rts_wr(rts_wr), .rts_wr_val(rts_wr_val), .rts_out(rts_out),
        .rd_req(rd_req), .rd_valid(rd_valid), .rd_data(rd_data),
        .chg_ack(chg_ack), .chg_pulse(chg_pulse), .chg_pend(chg_pend)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s at cycle %0d: actual %0h expected %0h", tag, n, act, exp);
        end
    endtask

    function automatic bit [2:0] read_word(input bit rts, input bit [1:0] lvl);
        return {rts, lvl};
    endfunction

    // advance one cycle, update model with the stimulus held across the edge, compare
    task automatic cycle();
        bit [1:0] old_lvl;
        bit       old_rts;
        bit [1:0] e_pulse;
        bit       e_rdv;
        @(negedge clk);
        n++;
        old_lvl = m_lvl;
        old_rts = m_rts;
        e_pulse = '0;
        e_rdv   = rd_req;
        if (n % T == 0) begin
            for (int i = 0; i < 2; i++) begin
                if (!m_primed[i]) begin
                    m_lvl[i] = line_drv[i]; m_primed[i] = 1'b1; m_cand[i] = 1'b0;
                end else if (line_drv[i] == m_lvl[i]) begin
                    m_cand[i] = 1'b0;
                end else if (m_cand[i]) begin
                    m_lvl[i] = line_drv[i]; m_cand[i] = 1'b0;
                    e_pulse[i] = detect_en;
                end else begin
                    m_cand[i] = 1'b1;
                end
            end
        end
        for (int i = 0; i < 2; i++) begin
            if (e_pulse[i])      m_pend[i] = 1'b1;
            else if (chg_ack[i]) m_pend[i] = 1'b0;
        end
        if (rts_wr) m_rts = rts_wr_val;
        check(chg_pulse == e_pulse, "R1 R3 R4 R5 R9 pulse", chg_pulse, e_pulse);
        check(chg_pend == m_pend, "R6 pending", chg_pend, m_pend);
        check(rts_out == m_rts, "R8 rts", rts_out, m_rts);
        check(rd_valid == e_rdv, "R7 valid", rd_valid, e_rdv);
        if (e_rdv)
            check(rd_data == read_word(old_rts, old_lvl), "R2 R7 read data",
                  rd_data, read_word(old_rts, old_lvl));
        rd_req = 1'b0; rts_wr = 1'b0; chg_ack = 2'b00;
    endtask

    task automatic wait_tick();
        do cycle(); while (n % T != 0);
    endtask

    task automatic do_read();
        rd_req = 1'b1;
        cycle();
        cycle();
    endtask

    initial begin
        int unsigned seed;
        seed = 32'd20240611;
        void'($urandom(seed));
        // R10: reset state
        repeat (4) @(posedge clk);
        @(negedge clk);
        check(chg_pulse == 2'b00, "R10 pulse in reset", chg_pulse, 0);
        check(chg_pend == 2'b00, "R10 pend in reset", chg_pend, 0);
        check(rd_valid == 1'b0, "R10 valid in reset", rd_valid, 0);
        check(rts_out == 1'b1, "R8 rts in reset", rts_out, 1);
        rst_n = 1'b1;
        // R2: before the first tick the levels read as zero
        do_read();
        // R2: first tick primes with no event
        wait_tick();
        do_read();
        // R3: single-sample glitch on clear-to-send is rejected
        line_drv[0] = 1'b0;
        wait_tick();
        line_drv[0] = 1'b1;
        wait_tick();
        wait_tick();
        do_read();
        // R4: carrier-detect drops and is confirmed
        line_drv[1] = 1'b0;
        wait_tick();
        wait_tick();
        do_read();
        // R6: acknowledge clears the flag
        chg_ack = 2'b10;
        cycle();
        // R5: detection disabled, level updates silently
        detect_en = 1'b0;
        line_drv[0] = 1'b0;
        wait_tick();
        wait_tick();
        do_read();
        detect_en = 1'b1;
        // R8: host writes to request-to-send
        rts_wr = 1'b1; rts_wr_val = 1'b0;
        cycle();
        do_read();
        rts_wr = 1'b1; rts_wr_val = 1'b1;
        cycle();
        // R9: both lines move together
        line_drv = 2'b11;
        wait_tick();
        wait_tick();
        // R6: acknowledge on the same edge as a new set
        line_drv[0] = 1'b0;
        wait_tick();
        repeat (T - 1) cycle();
        chg_ack = 2'b01;
        cycle();
        // random phase
        for (int k = 0; k < 6000; k++) begin
            detect_en = ($urandom_range(0, 7) != 0);
            rd_req    = ($urandom_range(0, 5) == 0);
            rts_wr    = ($urandom_range(0, 9) == 0);
            rts_wr_val = $urandom_range(0, 1);
            chg_ack   = ($urandom_range(0, 3) == 0) ? 2'($urandom_range(0, 3)) : 2'b00;
            cycle();
            if (n % T == 0 && $urandom_range(0, 2) == 0)
                line_drv = 2'($urandom_range(0, 3));
        end
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    // watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule